// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for a small 8-bit accumulator processor. A new computation begins with a one-cycle `start` pulse carrying the addressing-mode code, a tag naming the instruction class, and the current index register pair and stack pointer. The operand bytes that follow the opcode then arrive one per cycle over a valid/ready stream. Once the last byte the mode needs has been taken, the block pulses `done` with the address on `ea`.

The block supports an absolute address, the index pair with no offset, an 8-bit or 16-bit offset added to the index pair, an 8-bit or 16-bit offset added to the stack pointer, and two post-increment forms. In a post-increment form, the block waits after `done` for an operand-fetched pulse. In that same cycle it presents the incremented index pair with a one-cycle write enable. Post-increment is allowed only for certain instruction classes. Any other pairing raises `illegal` alongside `done`, and no write takes place.

Byte stream rules: `byte_ready` is high only while the block still needs bytes. A byte is taken on a clock edge where both `byte_valid` and `byte_ready` are high. The sender may insert idle cycles freely, and must hold the data until it is taken. Bytes offered while `byte_ready` is low are not consumed and have no effect.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (absolute) takes two stream bytes, the high byte first, and `ea` equals {first, second}.
- R2: Mode code 1 (index, no offset) takes no bytes, and `ea` equals the index pair captured at `start`.
- R3: Mode codes 3 and 4 take one byte, which is zero-extended as an unsigned offset and added to the index pair. Mode code 6 adds that zero-extended byte to the stack pointer.
- R4: Mode code 5 takes two bytes (high first) forming a 16-bit offset added to the index pair. Mode code 7 adds such an offset to the stack pointer.
- R5: Every address sum and the index increment wrap modulo 65536.
- R6: `done` is a one-cycle pulse. It comes in the cycle after the last needed byte is accepted, or in the cycle after `start` when the mode needs no bytes. It is low while bytes are still awaited.
- R7: `byte_ready` is low in reset and whenever no bytes are awaited. Bytes offered while `byte_ready` is low change no result, and idle gaps in `byte_valid` only delay `done`.
- R8: For mode code 2 (post-increment, no offset) with class 1 (move) or class 2 (compare-and-branch), and for mode code 4 (post-increment, 8-bit offset) with class 2, `ea` is computed from the unincremented pair. After `done`, `hx_wr_en` is high for exactly the one cycle in which `fetched` is high, with `hx_wr_data` equal to the pair plus one. It is never high before that pulse.
- R9: Mode code 2 with class 0 or 3, and mode code 4 with any class other than 2, assert `illegal` in the `done` cycle and never assert `hx_wr_en`. All other pairings leave `illegal` low.
- R10: A `start` pulse arriving while a computation is in progress is ignored.
- R11: After reset, `done`, `illegal`, `hx_wr_en` and `byte_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation (taken only when idle) |
| mode | input | 3 | Addressing-mode code, sampled with start |
| iclass | input | 2 | Instruction class: 0 other, 1 move, 2 compare-and-branch, 3 other |
| idx_in | input | 16 | Index register pair, sampled with start |
| sp_in | input | 16 | Stack pointer, sampled with start |
| byte_valid | input | 1 | Operand byte offered |
| byte_ready | output | 1 | Block will take an operand byte |
| byte_data | input | 8 | Operand byte |
| done | output | 1 | Address ready, one-cycle pulse |
| ea | output | 16 | Effective address, valid while done is high |
| illegal | output | 1 | Mode and class pairing not permitted, with done |
| fetched | input | 1 | Operand read has completed |
| hx_wr_en | output | 1 | Write the incremented index pair |
| hx_wr_data | output | 16 | Incremented index pair |

## Verification
A byte counter that drifts would show at once as `done` a cycle early or late, or as `byte_ready` staying high after the final byte. A shift register that takes bytes in the wrong order shows up as an `ea` with its halves swapped in the very `done` cycle. A wrong base or legality decode appears in that same `done` cycle as a mismatched `ea` or `illegal`. A post-increment state entered or left wrongly shows within one cycle of `fetched`, as a missing, early or extra `hx_wr_en`. The directed scenarios place each of these observations at a fixed cycle count from `start`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_IDX   = 3'd1,
    AM_IDXP  = 3'd2,
    AM_OFF8  = 3'd3,
    AM_OFF8P = 3'd4,
    AM_OFF16 = 3'd5,
    AM_SPO8  = 3'd6,
    AM_SPO16 = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    IC_OTHER = 2'd0,
    IC_MOVE  = 2'd1,
    IC_CBEQ  = 2'd2,
    IC_SPARE = 2'd3
  } iclass_e;

  typedef enum logic [1:0] {
    BASE_NONE  = 2'd0,
    BASE_INDEX = 2'd1,
    BASE_STACK = 2'd2
  } base_e;

  typedef struct packed {
    base_e            base;
    logic [CNT_W-1:0] nbytes;
    logic             postinc;
    logic             legal;
  } mode_info_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DONE    = 2'd2,
    ST_WB      = 2'd3
  } state_e;
endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] iclass,
  output mode_info_t info
);
  amode_e  m;
  iclass_e c;

  assign m = amode_e'(mode);
  assign c = iclass_e'(iclass);

  always_comb begin
    info = '{base: BASE_INDEX, nbytes: '0, postinc: 1'b0, legal: 1'b1};
    unique case (m)
      AM_ABS: begin
        info.base   = BASE_NONE;
        info.nbytes = 2'd2;
      end
      AM_IDX: ;
      AM_IDXP: begin
        info.postinc = 1'b1;
        info.legal   = (c == IC_MOVE) || (c == IC_CBEQ);
      end
      AM_OFF8: info.nbytes = 2'd1;
      AM_OFF8P: begin
        info.nbytes  = 2'd1;
        info.postinc = 1'b1;
        info.legal   = (c == IC_CBEQ);
      end
      AM_OFF16: info.nbytes = 2'd2;
      AM_SPO8: begin
        info.base   = BASE_STACK;
        info.nbytes = 2'd1;
      end
      AM_SPO16: begin
        info.base   = BASE_STACK;
        info.nbytes = 2'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_oprnd_collect.sv
module ea_oprnd_collect
  import ea_pkg::*;
#(
  parameter int BW = 8,
  parameter int NB = 2,
  localparam int OW = BW * NB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic [BW-1:0]    data,
  output logic [OW-1:0]    offset,
  output logic [CNT_W-1:0] count
);
  logic [OW-1:0] sh_q;

  generate
    if (NB > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sh_q <= '0;
        else if (clear)  sh_q <= '0;
        else if (accept) sh_q <= {sh_q[OW-BW-1:0], data};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sh_q <= '0;
        else if (clear)  sh_q <= '0;
        else if (accept) sh_q <= data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (accept) count <= count + 1'b1;
  end

  assign offset = sh_q;
endmodule

// File: rtl/ea_addsum.sv
module ea_addsum
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  base_e         base,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] base_val;

  always_comb begin
    unique case (base)
      BASE_INDEX: base_val = idx;
      BASE_STACK: base_val = sp;
      default:    base_val = '0;
    endcase
  end

  assign sum = AW'(base_val + offset);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [1:0]    iclass,
  input  logic [AW-1:0] idx_in,
  input  logic [AW-1:0] sp_in,
  input  logic          byte_valid,
  output logic          byte_ready,
  input  logic [BW-1:0] byte_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          illegal,
  input  logic          fetched,
  output logic          hx_wr_en,
  output logic [AW-1:0] hx_wr_data
);
  localparam int NB = AW / BW;

  state_e           st_q;
  mode_info_t       dec_info, info_q;
  logic [AW-1:0]    idx_q, sp_q, off;
  logic [CNT_W-1:0] cnt;
  logic             take_start, accept, last_byte;

  ea_mode_dec u_dec (
    .mode   (mode),
    .iclass (iclass),
    .info   (dec_info)
  );

  assign take_start = start && (st_q == ST_IDLE);
  assign byte_ready = (st_q == ST_COLLECT);
  assign accept     = byte_valid && byte_ready;
  assign last_byte  = accept && (CNT_W'(cnt + 1'b1) == info_q.nbytes);

  ea_oprnd_collect #(.BW(BW), .NB(NB)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (take_start),
    .accept (accept),
    .data   (byte_data),
    .offset (off),
    .count  (cnt)
  );

  ea_addsum #(.AW(AW)) u_add (
    .base   (info_q.base),
    .idx    (idx_q),
    .sp     (sp_q),
    .offset (off),
    .sum    (ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sp_q   <= '0;
      info_q <= '{base: BASE_NONE, nbytes: '0, postinc: 1'b0, legal: 1'b1};
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_start) begin
          idx_q  <= idx_in;
          sp_q   <= sp_in;
          info_q <= dec_info;
          st_q   <= (dec_info.nbytes == '0) ? ST_DONE : ST_COLLECT;
        end
        ST_COLLECT: if (last_byte) st_q <= ST_DONE;
        ST_DONE:    st_q <= (info_q.postinc && info_q.legal) ? ST_WB : ST_IDLE;
        ST_WB:      if (fetched) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = (st_q == ST_DONE);
  assign illegal    = done && !info_q.legal;
  assign hx_wr_en   = (st_q == ST_WB) && fetched;
  assign hx_wr_data = AW'(idx_q + 1'b1);
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          byte_valid,
  input logic          byte_ready,
  input logic          done,
  input logic          illegal,
  input logic          fetched,
  input logic          hx_wr_en,
  input logic [AW-1:0] hx_wr_data
);
  // R6: done never lasts two cycles
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6/R7: no byte is awaited in the cycle that reports the address
  p_ready_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !byte_ready);

  // R8: the write only ever coincides with the fetched pulse
  p_wr_with_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr_en |-> fetched);

  // R8: the write lasts a single cycle
  p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr_en |=> !hx_wr_en);

  // R8: no write is reported in the done cycle itself
  p_wr_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hx_wr_en);

  // R9: illegal appears only with done, and a rejected pairing never writes
  p_illegal_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
  p_illegal_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !hx_wr_en);

  // R11: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r11: assert (!done && !illegal && !hx_wr_en && !byte_ready);
    end
  end

  logic unused_ok;
  assign unused_ok = ^{start, byte_valid, hx_wr_data};
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .done       (done),
  .illegal    (illegal),
  .fetched    (fetched),
  .hx_wr_en   (hx_wr_en),
  .hx_wr_data (hx_wr_data)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  iclass = '0;
  logic [15:0] idx_in = '0, sp_in = '0;
  logic        byte_valid = 1'b0;
  logic        byte_ready;
  logic [7:0]  byte_data = '0;
  logic        done, illegal, fetched = 1'b0, hx_wr_en;
  logic [15:0] ea, hx_wr_data;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iclass(iclass),
    .idx_in(idx_in), .sp_in(sp_in), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .done(done), .ea(ea),
    .illegal(illegal), .fetched(fetched), .hx_wr_en(hx_wr_en),
    .hx_wr_data(hx_wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one computation; bytes b[0..nb-1], gap idle cycles before each byte.
  task automatic run(input string req, input logic [2:0] m, input logic [1:0] c,
                     input logic [15:0] hx, input logic [15:0] sp,
                     input int nb, input logic [7:0] b0, input logic [7:0] b1,
                     input int gap, input logic [15:0] exp_ea, input logic exp_ill);
    @(negedge clk);
    start = 1'b1; mode = m; iclass = c; idx_in = hx; sp_in = sp;
    @(negedge clk);
    start = 1'b0; idx_in = 16'h5A5A; sp_in = 16'hA5A5;
    for (int i = 0; i < nb; i++) begin
      for (int g = 0; g < gap; g++) begin
        chk({req, " ready while waiting"}, byte_ready, 1'b1);
        chk({req, " R6 no early done"}, done, 1'b0);
        @(negedge clk);
      end
      chk({req, " R7 ready"}, byte_ready, 1'b1);
      chk({req, " R6 no early done"}, done, 1'b0);
      byte_valid = 1'b1; byte_data = (i == 0) ? b0 : b1;
      @(negedge clk);
      byte_valid = 1'b0;
    end
    chk({req, " R6 done"}, done, 1'b1);
    chk({req, " ea"}, ea, exp_ea);
    chk({req, " R9 illegal"}, illegal, exp_ill);
    chk({req, " R7 ready low at done"}, byte_ready, 1'b0);
  endtask

  // After a non-writeback run: fetched must not produce a write.
  task automatic no_wb(input string req);
    @(negedge clk);
    chk({req, " R6 done single"}, done, 1'b0);
    fetched = 1'b1; #1;
    chk({req, " no writeback"}, hx_wr_en, 1'b0);
    @(negedge clk);
    fetched = 1'b0;
  endtask

  task automatic wb(input string req, input logic [15:0] exp_d);
    @(negedge clk);
    chk({req, " R8 no write before fetch"}, hx_wr_en, 1'b0);
    @(negedge clk);
    chk({req, " R8 still waiting"}, hx_wr_en, 1'b0);
    fetched = 1'b1; #1;
    chk({req, " R8 write with fetch"}, hx_wr_en, 1'b1);
    chk({req, " R8 write data"}, hx_wr_data, exp_d);
    @(negedge clk);
    fetched = 1'b0; #1;
    chk({req, " R8 single write"}, hx_wr_en, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 done", done, 1'b0);
    chk("R11 illegal", illegal, 1'b0);
    chk("R11 wr", hx_wr_en, 1'b0);
    chk("R11 ready", byte_ready, 1'b0);
  endtask

  task automatic t_abs();
    run("R1 abs", 3'd0, 2'd0, 16'hFFFF, 16'hFFFF, 2, 8'h12, 8'h34, 0, 16'h1234, 1'b0);
    no_wb("R1 abs");
  endtask

  task automatic t_idx();
    run("R2 idx", 3'd1, 2'd0, 16'hBEEF, 16'h0000, 0, 8'h00, 8'h00, 0, 16'hBEEF, 1'b0);
    no_wb("R2 idx");
  endtask

  task automatic t_off8();
    run("R3 off8", 3'd3, 2'd0, 16'h1000, 16'h0000, 1, 8'hF0, 8'h00, 0, 16'h10F0, 1'b0);
    no_wb("R3 off8");
    run("R3 sp8", 3'd6, 2'd0, 16'h0000, 16'h00FF, 1, 8'h81, 8'h00, 0, 16'h0180, 1'b0);
    no_wb("R3 sp8");
  endtask

  task automatic t_off16();
    run("R4 off16", 3'd5, 2'd0, 16'h1000, 16'h0000, 2, 8'h80, 8'h01, 0, 16'h9001, 1'b0);
    no_wb("R4 off16");
    run("R4 sp16", 3'd7, 2'd0, 16'h0000, 16'h0100, 2, 8'h12, 8'h34, 0, 16'h1334, 1'b0);
    no_wb("R4 sp16");
  endtask

  task automatic t_wrap();
    run("R5 wrap idx16", 3'd5, 2'd0, 16'hFFF0, 16'h0000, 2, 8'h00, 8'h20, 0, 16'h0010, 1'b0);
    no_wb("R5 wrap idx16");
    run("R5 wrap sp8", 3'd6, 2'd0, 16'h0000, 16'hFFFF, 1, 8'h02, 8'h00, 0, 16'h0001, 1'b0);
    no_wb("R5 wrap sp8");
    run("R5 wrap inc", 3'd2, 2'd2, 16'hFFFF, 16'h0000, 0, 8'h00, 8'h00, 0, 16'hFFFF, 1'b0);
    wb("R5 wrap inc", 16'h0000);
  endtask

  task automatic t_stall();
    // Bytes offered while idle must not be consumed
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'hEE;
    chk("R7 idle ready low", byte_ready, 1'b0);
    @(negedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    run("R7 gaps", 3'd7, 2'd1, 16'h0000, 16'h2000, 2, 8'h01, 8'h02, 3, 16'h2102, 1'b0);
    no_wb("R7 gaps");
  endtask

  task automatic t_postinc();
    run("R8 move idxp", 3'd2, 2'd1, 16'h3000, 16'h0000, 0, 8'h00, 8'h00, 0, 16'h3000, 1'b0);
    wb("R8 move idxp", 16'h3001);
    run("R8 cbeq off8p", 3'd4, 2'd2, 16'h2000, 16'h0000, 1, 8'h10, 8'h00, 1, 16'h2010, 1'b0);
    wb("R8 cbeq off8p", 16'h2001);
  endtask

  task automatic t_illegal();
    run("R9 other idxp", 3'd2, 2'd0, 16'h4000, 16'h0000, 0, 8'h00, 8'h00, 0, 16'h4000, 1'b1);
    no_wb("R9 other idxp");
    run("R9 spare idxp", 3'd2, 2'd3, 16'h4100, 16'h0000, 0, 8'h00, 8'h00, 0, 16'h4100, 1'b1);
    no_wb("R9 spare idxp");
    run("R9 move off8p", 3'd4, 2'd1, 16'h4000, 16'h0000, 1, 8'h08, 8'h00, 0, 16'h4008, 1'b1);
    no_wb("R9 move off8p");
    run("R9 cbeq off16 legal", 3'd5, 2'd2, 16'h0001, 16'h0000, 2, 8'h00, 8'h01, 0, 16'h0002, 1'b0);
    no_wb("R9 cbeq off16 legal");
  endtask

  task automatic t_busy_start();
    @(negedge clk);
    start = 1'b1; mode = 3'd3; iclass = 2'd0; idx_in = 16'h1000;
    @(negedge clk);
    start = 1'b1; mode = 3'd1; idx_in = 16'h2222;
    @(negedge clk);
    start = 1'b0;
    chk("R10 still collecting", byte_ready, 1'b1);
    chk("R10 no done", done, 1'b0);
    byte_valid = 1'b1; byte_data = 8'h05;
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R10 done", done, 1'b1);
    chk("R10 ea", ea, 16'h1005);
    no_wb("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_abs();
    t_idx();
    t_off8();
    t_off16();
    t_wrap();
    t_stall();
    t_postinc();
    t_illegal();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule